// File: doc/BRIEF.md
# SPI Master with FIFO-Gated Chip Select

This block is a byte-wide SPI master in clock mode 0. A host pushes bytes into a 128-entry transmit queue through a valid/ready write port. The shift engine takes one byte at a time from the queue and clocks it out MSB first. It gathers the byte that the slave returns on MISO and presents that byte on a receive output with a single-cycle strobe. The serial clock comes from a divider of the system clock, with a half period of `HALF_DIV` system cycles.

Chip select has two modes. In automatic mode it follows the queue. It asserts while data is waiting or a byte is shifting, and it releases as soon as the last queued byte has left. If the host stalls, one logical transfer therefore becomes two transfers in the slave's view. In held mode, a control bit keeps the select low across such stalls. Every stall of this kind that happens while the select is held raises a sticky underrun flag, which the host clears with a strobe.

Top module: `spi_fifo_master`

## Requirements
- R1: While reset is applied and after it is released, `spi_cs_n` is 1 and `spi_sclk`, `spi_mosi`, `rx_valid` and `under_flag` are 0. `wr_ready` is 1.
- R2: A byte is accepted on every clock where `wr_valid` and `wr_ready` are both 1. The queue holds 128 bytes, and `wr_ready` is 0 exactly while 128 bytes are queued. Bytes go out in the order they were accepted.
- R3: Each byte is sent MSB first in 8 SCLK periods. SCLK stays low for `HALF_DIV` cycles and then high for `HALF_DIV` cycles. MOSI changes only while SCLK is low. Consecutive bytes are separated by one system cycle with SCLK low.
- R4: MISO is sampled at each SCLK rise, MSB first. In the cycle after the eighth falling edge, `rx_valid` is 1 for exactly one cycle and `rx_data` shows the byte. `rx_data` holds its value until the next byte completes.
- R5: With `cs_mode`=0 (automatic), `spi_cs_n` in each cycle is the inverse of (a byte was shifting, or the queue was non-empty) in the previous cycle.
- R6: In automatic mode, a gap in host writes that lets the queue and the engine go idle makes `spi_cs_n` rise and later fall again. A queue that is kept fed causes only one rise, at the end.
- R7: With `cs_mode`=1 (held), `spi_cs_n` is the inverse of (`cs_hold`, or a byte was shifting) in the previous cycle. No new byte starts while `cs_hold` is 0.
- R8: `spi_sclk` is 0 in every cycle in which `spi_cs_n` is 1.
- R9: `under_flag` is set in the cycle after a byte completes in held mode with `cs_hold`=1, provided the queue is empty and no write is accepted in that cycle.
- R10: A `under_clr` pulse clears `under_flag` in the next cycle. If a set event happens in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_data | input | 8 | Byte to queue |
| wr_valid | input | 1 | Host offers `wr_data` |
| wr_ready | output | 1 | Queue has room |
| cs_mode | input | 1 | 0 = automatic select, 1 = held select |
| cs_hold | input | 1 | Held mode: 1 keeps the select asserted |
| under_clr | input | 1 | Clears the underrun flag |
| under_flag | output | 1 | Sticky underrun indication |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
`wr_ready` reflects the queue count in the same cycle. The select, the underrun flag and the receive strobe are all registered, so each one is due exactly one clock after the state that determines it. SCLK and MOSI change at the edge where the divider wraps. The bench keeps a behavioural model whose state advances at the same rising edge as the design, using the same input values. Every output is compared at the following falling edge, so each expected value is checked in the cycle the requirements fix for it. Directed checks then count select rises across stalls, count rejected writes at a full queue, and confirm the state of the flag after set and clear.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {CS_AUTO = 1'b0, CS_HELD = 1'b1} cs_mode_e;
endpackage

// File: rtl/spi_txq.sv
module spi_txq
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  byte_t push_data,
  input  logic  pop,
  output byte_t head,
  output logic  empty,
  output logic  full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  byte_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
    if (push && !pop)      count_d = count_q + 1'b1;
    else if (pop && !push) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_data;
  end

  assign head  = mem[rd_ptr_q];
  assign empty = (count_q == '0);
  assign full  = (count_q == CW'(DEPTH));

  // R2
  pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
endmodule

// File: rtl/spi_shift.sv
module spi_shift
  import spi_fifo_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_ok,
  input  logic  q_empty,
  input  byte_t q_head,
  output logic  q_pop,
  input  logic  miso,
  output logic  sclk,
  output logic  mosi,
  output logic  busy,
  output logic  byte_done,
  output byte_t rx_data,
  output logic  rx_valid
);
  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  logic             busy_q, busy_d, sclk_q, sclk_d, rxv_q, rxv_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  byte_t            tx_q, tx_d, rx_q, rx_d, rxd_q, rxd_d;
  logic             tick, rise, fall;

  always_comb begin
    tick      = busy_q && (div_q == DIV_W'(HALF_DIV - 1));
    rise      = tick && !sclk_q;
    fall      = tick && sclk_q;
    byte_done = fall && (bit_q == BIT_W'(BYTE_W - 1));
    q_pop     = !busy_q && !q_empty && start_ok;

    busy_d = busy_q;
    sclk_d = sclk_q;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    rxd_d  = rxd_q;
    rxv_d  = 1'b0;

    if (busy_q) begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (rise) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[BYTE_W-2:0], miso};
      end
      if (fall) begin
        sclk_d = 1'b0;
        if (byte_done) begin
          busy_d = 1'b0;
          rxv_d  = 1'b1;
          rxd_d  = rx_q;
        end else begin
          bit_d = bit_q + 1'b1;
          tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end

    if (q_pop) begin
      busy_d = 1'b1;
      tx_d   = q_head;
      div_d  = '0;
      sclk_d = 1'b0;
      bit_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rxd_q  <= '0;
      rxv_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      rxd_q  <= rxd_d;
      rxv_q  <= rxv_d;
    end
  end

  assign sclk     = sclk_q;
  assign mosi     = busy_q & tx_q[BYTE_W-1];
  assign busy     = busy_q;
  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi));
  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q);
endmodule

// File: rtl/spi_csctl.sv
module spi_csctl
  import spi_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_mode,
  input  logic cs_hold,
  input  logic busy,
  input  logic q_empty,
  input  logic byte_done,
  input  logic wr_fire,
  input  logic under_clr,
  output logic start_ok,
  output logic cs_n,
  output logic under_flag
);
  logic held;
  logic cs_n_q, cs_n_d, flag_q, flag_d, under_evt;

  always_comb begin
    held      = (cs_mode_e'(cs_mode) == CS_HELD);
    start_ok  = held ? cs_hold : 1'b1;
    cs_n_d    = !(busy || (held ? cs_hold : !q_empty));
    under_evt = byte_done && q_empty && !wr_fire && held && cs_hold;
    flag_d    = flag_q;
    if (under_evt)      flag_d = 1'b1;
    else if (under_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      cs_n_q <= cs_n_d;
      flag_q <= flag_d;
    end
  end

  assign cs_n       = cs_n_q;
  assign under_flag = flag_q;

  // R9
  under_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cs_mode && cs_hold));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH    = 128,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wr_data,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic       cs_mode,
  input  logic       cs_hold,
  input  logic       under_clr,
  output logic       under_flag,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       q_full, q_empty, q_pop, wr_fire;
  logic       busy, byte_done, start_ok;
  byte_t      q_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign wr_ready = !q_full;
  assign wr_fire  = wr_valid && !q_full;

  spi_txq #(.DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n_s), .push(wr_fire), .push_data(wr_data),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  spi_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .start_ok(start_ok), .q_empty(q_empty),
    .q_head(q_head), .q_pop(q_pop), .miso(spi_miso), .sclk(spi_sclk),
    .mosi(spi_mosi), .busy(busy), .byte_done(byte_done),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  spi_csctl u_cs (
    .clk(clk), .rst_n(rst_n_s), .cs_mode(cs_mode), .cs_hold(cs_hold),
    .busy(busy), .q_empty(q_empty), .byte_done(byte_done), .wr_fire(wr_fire),
    .under_clr(under_clr), .start_ok(start_ok), .cs_n(spi_cs_n),
    .under_flag(under_flag)
  );

  // R8
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    spi_cs_n |-> !spi_sclk);
  // R7
  sw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cs_mode && !cs_hold && !busy) |=> !busy);
endmodule

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
  localparam int DEPTH = 128;
  localparam int H     = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] wr_data;
  logic       wr_valid, wr_ready, cs_mode, cs_hold, under_clr, under_flag;
  logic [7:0] rx_data;
  logic       rx_valid, spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  always #10 clk = ~clk;

  spi_fifo_master #(.DEPTH(DEPTH), .HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .cs_mode(cs_mode), .cs_hold(cs_hold),
    .under_clr(under_clr), .under_flag(under_flag), .rx_data(rx_data),
    .rx_valid(rx_valid), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, nm, act, exp, cyc);
    end
  endtask

  // reference model state
  logic [7:0] mq[$];
  int   m_sync = 0, m_div = 0, m_bit = 0, sz;
  bit   m_busy = 0, m_sclk = 0, m_rxv = 0, m_flag = 0, m_csn = 1, m_started = 0;
  bit   fire, allow, start, bdone;
  logic [7:0] m_tx = 0, m_rx = 0, m_rxd = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || m_sync < 2) begin
      if (!rst_n) m_sync = 0; else m_sync++;
      m_busy = 0; m_sclk = 0; m_div = 0; m_bit = 0; m_tx = 0; m_rx = 0;
      m_rxd = 0; m_rxv = 0; m_flag = 0; m_csn = 1; mq.delete();
    end else begin
      sz    = mq.size();
      fire  = wr_valid && (sz < DEPTH);
      allow = cs_mode ? cs_hold : 1'b1;
      start = !m_busy && (sz > 0) && allow;
      bdone = 0;
      m_csn = !(m_busy || (cs_mode ? cs_hold : (sz != 0)));
      m_rxv = 0;
      if (m_busy) begin
        if (m_div == H - 1) begin
          m_div = 0;
          if (!m_sclk) begin
            m_sclk = 1; m_rx = {m_rx[6:0], spi_miso};
          end else begin
            m_sclk = 0;
            if (m_bit == 7) begin m_busy = 0; bdone = 1; end
            else begin m_bit++; m_tx = m_tx << 1; end
          end
        end else m_div++;
      end
      if (bdone) begin m_rxv = 1; m_rxd = m_rx; end
      if (bdone && sz == 0 && !fire && cs_mode && cs_hold) m_flag = 1;
      else if (under_clr) m_flag = 0;
      if (start) begin
        m_tx = mq.pop_front(); m_busy = 1; m_div = 0; m_sclk = 0; m_bit = 0;
      end
      if (fire) mq.push_back(wr_data);
    end
    m_started = 1;
  end

  // per-cycle comparison and monitors
  int cs_rises = 0, sclk_rises = 0, r8_bad = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (m_started) begin
      chk("R2", "wr_ready", wr_ready, (mq.size() < DEPTH));
      chk("R3", "sclk", spi_sclk, m_sclk);
      chk("R3", "mosi", spi_mosi, m_busy ? m_tx[7] : 1'b0);
      chk("R4", "rx_valid", rx_valid, m_rxv);
      chk("R4", "rx_data", rx_data, m_rxd);
      chk(cs_mode ? "R7" : "R5", "cs_n", spi_cs_n, m_csn);
      chk("R9", "under_flag", under_flag, m_flag);
    end
    if (spi_cs_n && !prev_cs) cs_rises++;
    if (spi_sclk && !prev_sclk) sclk_rises++;
    if (spi_cs_n && spi_sclk) r8_bad++;
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    spi_miso = lfsr[0];
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  bit acc;
  int n_acc;
  task automatic push(input logic [7:0] b);
    wr_data = b; wr_valid = 1'b1;
    do begin
      @(negedge clk); acc = wr_ready;
      @(posedge clk); #2;
    end while (!acc);
    wr_valid = 1'b0;
  endtask

  task automatic try_push(input logic [7:0] b);
    wr_data = b; wr_valid = 1'b1;
    @(negedge clk); acc = wr_ready;
    @(posedge clk); #2;
    wr_valid = 1'b0;
    if (acc) n_acc++;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  int base_rises, base_sclk;
  initial begin
    rst_n = 1'b0; wr_data = 8'h00; wr_valid = 1'b0; cs_mode = 1'b0;
    cs_hold = 1'b0; under_clr = 1'b0; spi_miso = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n", spi_cs_n, 1'b1);
    chk("R1", "sclk", spi_sclk, 1'b0);
    chk("R1", "mosi", spi_mosi, 1'b0);
    chk("R1", "rx_valid", rx_valid, 1'b0);
    chk("R1", "under_flag", under_flag, 1'b0);
    chk("R1", "wr_ready", wr_ready, 1'b1);
    step(1);

    // automatic mode with a host stall: R5, R6
    base_rises = cs_rises;
    push(8'hA5); push(8'h3C); push(8'hF0);
    step(150);
    @(negedge clk);
    chk("R5", "cs_n idle after drain", spi_cs_n, 1'b1);
    step(1);
    push(8'h81); push(8'h7E);
    step(100);
    @(negedge clk);
    chk("R6", "cs rises across stall", cs_rises - base_rises, 2);
    step(1);

    // held mode: R7, R9, R10
    cs_mode = 1'b1; cs_hold = 1'b1;
    step(2);
    base_rises = cs_rises;
    push(8'h5A); push(8'hC3);
    step(120);
    @(negedge clk);
    chk("R7", "cs_n held across underrun", spi_cs_n, 1'b0);
    chk("R9", "under_flag set", under_flag, 1'b1);
    step(1);
    push(8'h0F);
    step(60);
    @(negedge clk);
    chk("R7", "no cs rise while held", cs_rises - base_rises, 0);
    step(1);
    under_clr = 1'b1;
    step(1);
    under_clr = 1'b0;
    step(1);
    @(negedge clk);
    chk("R10", "under_flag cleared", under_flag, 1'b0);
    step(1);
    cs_hold = 1'b0;
    step(3);
    @(negedge clk);
    chk("R7", "cs_n released", spi_cs_n, 1'b1);
    step(1);

    // held mode, hold low: queue fills, nothing starts (R2, R7)
    base_sclk = sclk_rises;
    n_acc = 0;
    for (int i = 0; i < 130; i++) try_push(8'(i * 37 + 11));
    @(negedge clk);
    chk("R2", "accepted count at full", n_acc, DEPTH);
    chk("R2", "wr_ready low when full", wr_ready, 1'b0);
    chk("R7", "no sclk while hold low", sclk_rises - base_sclk, 0);
    step(1);

    // automatic mode drains a full queue in one select window (R6)
    base_rises = cs_rises;
    cs_mode = 1'b0;
    step(DEPTH * (16 * H + 1) + 200);
    @(negedge clk);
    chk("R6", "single cs rise for fed queue", cs_rises - base_rises, 1);
    chk("R2", "wr_ready after drain", wr_ready, 1'b1);
    chk("R8", "sclk idle while cs high", r8_bad, 0);
    finish_run();
  end
endmodule